// File: doc/BRIEF.md
# Blanking-Aware Status Register Overlay

This block sits between a bus master and a peripheral controller's register file. It takes over one control/status register and passes every other access through unchanged. A read of the captured address returns a composite word. Bit 7 of that word is a vertical-blanking flag, computed live by comparing the current raster line with programmable first and last display lines. Bits 6 to 2 come from a small stored control register. Bits 1 and 0 are fixed at one.

A write to the captured address updates only the stored control field and never reaches the controller. An external write-lock input, when nonzero, discards every write, whether captured or pass-through. The raster line and both display limits are plain inputs.

The request side uses a valid/ready handshake, and so does the controller side. A captured access, or any write that the lock discards, is accepted in the cycle it is presented, so `req_ready` is 1. Any other access takes its `req_ready` from `dn_ready`. The request fields must stay stable while `req_valid` is high and `req_ready` is low. Read data is combinational and is valid in the same cycle as the handshake.

Top module: `stat_overlay`

## Requirements
- R1: An access is captured when the 8-bit field `(req_addr >> 16) & 0x37` equals 0x20 or 0x30 and `req_addr[6:2]` is zero; `req_addr[1:0]` does not take part in the match.
- R2: On a captured read, `req_rdata[7]` is 1 when `raster_line <= disp_start` or `raster_line >= disp_end`, and 0 otherwise.
- R3: On a captured read, `req_rdata[6:2]` hold the stored control field, `req_rdata[1:0]` are both 1, and all bits above bit 7 are 0.
- R4: An accepted captured write with `wr_lock` zero stores `req_wdata & 0x7C` into the control field, and `dn_valid` stays 0.
- R5: While `wr_lock` is nonzero, any write is accepted with `req_ready` 1 and `dn_valid` 0, and the control field keeps its value.
- R6: A non-captured access that is not discarded drives `dn_valid` equal to `req_valid`, and passes the address, write flag, write data and byte mask through unchanged. For such an access, `req_ready` equals `dn_ready` and `req_rdata` equals `dn_rdata`.
- R7: After reset the control field is 0, so a captured read returns 0x03 or 0x83.
- R8: A captured access is accepted in its own cycle whatever the value of `dn_ready`.
- R9: Without `req_valid` high, nothing is forwarded and the control field does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte mask |
| req_rdata | output | 32 | Read data, same cycle |
| dn_valid | output | 1 | Request valid to controller |
| dn_ready | input | 1 | Controller accepts |
| dn_write | output | 1 | Write flag to controller |
| dn_addr | output | 32 | Address to controller |
| dn_wdata | output | 32 | Write data to controller |
| dn_be | output | 4 | Byte mask to controller |
| dn_rdata | input | 32 | Controller read data |
| raster_line | input | 10 | Current raster line |
| disp_start | input | 10 | First display line |
| disp_end | input | 10 | Last display line |
| wr_lock | input | 8 | Nonzero discards all writes |

## Verification
The embedded properties watch every cycle for the following:
- a captured access or a locked write reaching the controller;
- a captured access stalling;
- captured read data with wrong fixed bits;
- the control field changing under the lock or with no request.

Some behaviour can only be shown by the bench's scenarios:
- the exact decode boundary, including the ignored low address bits and near-miss selector values;
- the blanking flag exactly at equality with either limit;
- that a write really lands as the masked value;
- that a reset in mid-run clears a stored field.

// File: rtl/stat_overlay_pkg.sv
package stat_overlay_pkg;
  typedef logic [7:0] ctrl_t;
  localparam ctrl_t CTRL_KEEP  = 8'h7C;
  localparam ctrl_t SEL_MASK   = 8'h37;
  localparam ctrl_t SEL_HIT_LO = 8'h20;
  localparam ctrl_t SEL_HIT_HI = 8'h30;
  localparam int    SEL_SHIFT  = 16;
  localparam int    OFF_LSB    = 2;
  localparam int    OFF_W      = 5;
endpackage

// File: rtl/stat_overlay_decode.sv
module stat_overlay_decode
  import stat_overlay_pkg::*;
(
  input  logic [7:0]       sel_field,
  input  logic [OFF_W-1:0] off_field,
  output logic             hit
);
  ctrl_t masked;
  always_comb begin
    masked = sel_field & SEL_MASK;
    hit    = ((masked == SEL_HIT_LO) || (masked == SEL_HIT_HI)) && (off_field == '0);
  end
endmodule

// File: rtl/stat_overlay_blank.sv
module stat_overlay_blank #(
  parameter int LINE_W = 10
) (
  input  logic [LINE_W-1:0] line,
  input  logic [LINE_W-1:0] first_line,
  input  logic [LINE_W-1:0] last_line,
  output logic              blank
);
  always_comb blank = (line <= first_line) || (line >= last_line);
endmodule

// File: rtl/stat_overlay_ctrl.sv
module stat_overlay_ctrl
  import stat_overlay_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  ctrl_t din,
  output ctrl_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= din & CTRL_KEEP;
  end

  // R4
  ctrl_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~CTRL_KEEP) == '0);
endmodule

// File: rtl/stat_overlay.sv
module stat_overlay
  import stat_overlay_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINE_W = 10,
  parameter int LOCK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic [DATA_W-1:0] req_rdata,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_write,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_wdata,
  output logic [DATA_W/8-1:0] dn_be,
  input  logic [DATA_W-1:0] dn_rdata,
  input  logic [LINE_W-1:0] raster_line,
  input  logic [LINE_W-1:0] disp_start,
  input  logic [LINE_W-1:0] disp_end,
  input  logic [LOCK_W-1:0] wr_lock
);
  localparam int UPPER_W = DATA_W - 8;

  logic  hit, blank, wr_drop, ovl_we;
  ctrl_t ctrl_q;
  logic [DATA_W-1:0] ovl_word;

  stat_overlay_decode u_dec (
    .sel_field (req_addr[SEL_SHIFT +: 8]),
    .off_field (req_addr[OFF_LSB +: OFF_W]),
    .hit       (hit)
  );

  stat_overlay_blank #(.LINE_W(LINE_W)) u_blank (
    .line       (raster_line),
    .first_line (disp_start),
    .last_line  (disp_end),
    .blank      (blank)
  );

  stat_overlay_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ovl_we),
    .din   (req_wdata[7:0]),
    .q     (ctrl_q)
  );

  always_comb begin
    wr_drop   = req_write && (wr_lock != '0);
    ovl_we    = req_valid && hit && req_write && !wr_drop;
    dn_valid  = req_valid && !hit && !wr_drop;
    req_ready = (hit || wr_drop) ? 1'b1 : dn_ready;
    ovl_word  = {{UPPER_W{1'b0}}, blank, ctrl_q[6:2], 2'b11};
    req_rdata = hit ? ovl_word : dn_rdata;
    dn_write  = req_write;
    dn_addr   = req_addr;
    dn_wdata  = req_wdata;
    dn_be     = req_be;
  end

  // R4
  hit_not_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit) |-> !dn_valid);
  // R5
  lock_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && wr_lock != '0) |-> (!dn_valid && req_ready));
  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && wr_lock != '0) |=> $stable(ctrl_q));
  // R8
  hit_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit) |-> req_ready);
  // R3
  fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit && !req_write) |-> (req_rdata[1:0] == 2'b11));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(ctrl_q));
  // R9
  idle_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !dn_valid);
endmodule

// File: tb/stat_overlay_test.sv
module stat_overlay_test;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, dn_ready = 0;
  logic req_ready, dn_valid, dn_write;
  logic [31:0] req_addr = 0, req_wdata = 0, req_rdata, dn_addr, dn_wdata, dn_rdata = 0;
  logic [3:0]  req_be = 0, dn_be;
  logic [9:0]  raster_line = 0, disp_start = 20, disp_end = 200;
  logic [7:0]  wr_lock = 0;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  stat_overlay uut (.*);

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [9:0]  line;
    logic [7:0]  lock;
    logic        dnr;
    logic [31:0] dnd;
    logic        chk_rd;
    logic [31:0] erd;
    logic        erdy;
    logic        ednv;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 32'h0020_0000, 32'h0, 10'd50,  8'h00, 1'b0, 32'h0,        1'b1, 32'h03,       1'b1, 1'b0}, // R7 R2
    '{1'b0, 32'h0030_0000, 32'h0, 10'd20,  8'h00, 1'b0, 32'h0,        1'b1, 32'h83,       1'b1, 1'b0}, // R2 start edge
    '{1'b1, 32'h0020_0000, 32'hFFFF_FFFF, 10'd50, 8'h00, 1'b0, 32'h0, 1'b0, 32'h0,        1'b1, 1'b0}, // R4
    '{1'b0, 32'h0020_0000, 32'h0, 10'd200, 8'h00, 1'b0, 32'h0,        1'b1, 32'hFF,       1'b1, 1'b0}, // R3 end edge
    '{1'b1, 32'h0020_0000, 32'h0, 10'd50,  8'h01, 1'b0, 32'h0,        1'b0, 32'h0,        1'b1, 1'b0}, // R5
    '{1'b0, 32'h0020_0000, 32'h0, 10'd100, 8'h00, 1'b0, 32'h0,        1'b1, 32'h7F,       1'b1, 1'b0}, // R5 kept
    '{1'b0, 32'h0021_0000, 32'h0, 10'd100, 8'h00, 1'b0, 32'hDEADBEEF, 1'b1, 32'hDEADBEEF, 1'b0, 1'b1}, // R1 R6
    '{1'b0, 32'h0020_0004, 32'h0, 10'd100, 8'h00, 1'b1, 32'h12345678, 1'b1, 32'h12345678, 1'b1, 1'b1}, // R1 R6
    '{1'b1, 32'h0040_0000, 32'hA5, 10'd100, 8'h00, 1'b1, 32'h0,       1'b0, 32'h0,        1'b1, 1'b1}, // R6
    '{1'b1, 32'h0040_0000, 32'hA5, 10'd100, 8'h80, 1'b0, 32'h0,       1'b0, 32'h0,        1'b1, 1'b0}, // R5
    '{1'b1, 32'h0030_0002, 32'h55, 10'd100, 8'h00, 1'b0, 32'h0,       1'b0, 32'h0,        1'b1, 1'b0}, // R1 R4 R8
    '{1'b0, 32'h0320_0000, 32'h0, 10'd21,  8'h00, 1'b0, 32'h0,        1'b1, 32'h57,       1'b1, 1'b0}, // R1 R2
    '{1'b0, 32'h0020_0000, 32'h0, 10'd19,  8'h00, 1'b0, 32'h0,        1'b1, 32'hD7,       1'b1, 1'b0}  // R2
  };

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [31:0] a, input logic [31:0] d,
                       input logic [9:0] ln, input logic [7:0] lk, input logic dr, input logic [31:0] dd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    raster_line = ln; wr_lock = lk; dn_ready = dr; dn_rdata = dd;
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0; req_write = 0; wr_lock = 0;
    #2;
  endtask

  initial begin
    #(CLK_P * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R7 reset state read
    drive(0, 32'h0020_0000, 0, 10'd50, 0, 0, 0);
    check(req_rdata == 32'h03, "R7 reset read", req_rdata, 32'h03);
    idle();

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].wr, TBL[i].addr, TBL[i].wd, TBL[i].line, TBL[i].lock, TBL[i].dnr, TBL[i].dnd);
      if (TBL[i].chk_rd)
        check(req_rdata == TBL[i].erd, $sformatf("vec %0d rdata", i), req_rdata, TBL[i].erd);
      check(req_ready == TBL[i].erdy, $sformatf("vec %0d ready", i), {31'b0, req_ready}, {31'b0, TBL[i].erdy});
      check(dn_valid == TBL[i].ednv, $sformatf("vec %0d dn_valid", i), {31'b0, dn_valid}, {31'b0, TBL[i].ednv});
    end
    idle();

    // R6 fields pass through unchanged
    req_be = 4'b1010;
    drive(1, 32'h0055_0010, 32'hCAFE_F00D, 10'd100, 0, 1, 0);
    check(dn_addr == 32'h0055_0010, "R6 addr", dn_addr, 32'h0055_0010);
    check(dn_wdata == 32'hCAFE_F00D, "R6 wdata", dn_wdata, 32'hCAFE_F00D);
    check(dn_be == 4'b1010 && dn_write, "R6 be/write", {28'b0, dn_be}, 32'hA);
    idle();

    // R9 write on hit with valid low has no effect
    @(negedge clk);
    req_valid = 0; req_write = 1; req_addr = 32'h0020_0000; req_wdata = 32'h0; #2;
    check(!dn_valid, "R9 no forward", {31'b0, dn_valid}, 0);
    drive(0, 32'h0020_0000, 0, 10'd100, 0, 0, 0);
    check(req_rdata == 32'h57, "R9 ctrl kept", req_rdata, 32'h57);
    idle();

    // R7 reset mid-run clears stored field
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    drive(0, 32'h0030_0000, 0, 10'd250, 0, 0, 0);
    check(req_rdata == 32'h83, "R7 reset clears", req_rdata, 32'h83);
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule